// File: doc/BRIEF.md
# SDRAM Bank State and Command Legality Monitor

This block is a passive watcher for a synchronous DRAM command bus. On every rising clock edge it decodes the command strobes, the bank select and the auto-precharge/all-banks address bit. It keeps a small state machine for each bank: idle, opening, open, reading, writing, closing or refreshing. Each bank machine is advanced by the legal commands and by per-bank clock-count timers.

The monitor flags two kinds of fault. The first is a command that the addressed bank, or the device as a whole, cannot accept in its present state. The second is a command that comes too early under one of the cycle-count spacing rules: open-to-access, open-to-close, open-to-open across banks, close-to-idle and refresh-to-idle. A fault is reported as a one-clock pulse with a three-bit code that names the broken rule, and the offending command is discarded.

The current state of every bank is exposed on a packed output vector so that a surrounding environment can observe it. The data array is not modelled, and neither are power-down or self refresh.

Top module: `sdram_bank_monitor`

## Requirements
- R1: After reset every bank reports IDLE and no error is flagged. Bank i occupies bank_state[3i+2:3i]. The encodings are IDLE=0, OPENING=1, OPEN=2, READING=3, WRITING=4, CLOSING=5 and REFRESHING=6.
- R2: The command is taken from {ras_n,cas_n,we_n} as follows: 011 opens a row, 101 reads, 100 writes, 010 closes (precharge), 001 refreshes, 000 loads the mode register, 110 stops a burst and 111 does nothing. A command is acted on only when cs_n is low and cke was high at the previous clock edge. Otherwise it has no effect and raises no error.
- R3: An open command to an IDLE bank shows OPENING from the next clock. The bank becomes OPEN after T_RCD clocks. A read or write sampled while the bank is still OPENING is rejected with code 4.
- R4: A read or write to a bank that is IDLE, CLOSING or REFRESHING is rejected with code 1.
- R5: An open command to a bank that is not IDLE (this includes refreshing) is rejected with code 2.
- R6: A refresh or mode-register load while any bank is not IDLE is rejected with code 3. A legal refresh puts every bank in REFRESHING, and all banks return to IDLE T_RC clocks later.
- R7: A close sampled fewer than T_RAS clocks after that bank's open is rejected with code 5. A legal close puts the bank in CLOSING, and the bank returns to IDLE T_RP clocks later. With a10 high, the close applies to every opened bank and is checked against all of them.
- R8: An open command sampled fewer than T_RRD clocks after the previous accepted open is rejected with code 6.
- R9: A legal read or write puts the bank in READING or WRITING for BURST_LEN clocks, after which it is OPEN again. A new read or write to any bank ends an earlier burst that has no auto-precharge, and that bank becomes OPEN.
- R10: A read or write issued with a10 high carries auto-precharge. While such a burst runs, any read, write, burst stop or close that would touch it is rejected with code 7. Its bank shows CLOSING from the last burst clock and becomes IDLE T_RP clocks after that clock.
- R11: A burst stop returns the bursting bank to OPEN.
- R12: A rejected command raises err_valid for exactly one clock after the edge at which it was sampled, with its code on err_code, and it changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks qualifier |
| err_valid | output | 1 | One-clock fault pulse |
| err_code | output | 3 | Code of the broken rule |
| bank_state | output | 3*NUM_BANKS | Packed state of every bank |

## Verification
The command stream opens two banks back to back, so the cross-bank spacing check is exercised before the open-to-access and open-to-close timers run out. Each rule is then hit both one clock early and exactly on time, which separates an off-by-one in the timers from a missing check. Bursts are interleaved across banks, with and without auto-precharge, to distinguish burst termination from the auto-precharge lockout. Refresh and the all-bank close are tried both against busy banks and against fully idle ones. Gated-clock and deselected cycles carry real opens, to show that they are discarded.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

   typedef enum logic [2:0] {
      BK_IDLE    = 3'd0,
      BK_OPENING = 3'd1,
      BK_OPEN    = 3'd2,
      BK_RD      = 3'd3,
      BK_WR      = 3'd4,
      BK_CLOSING = 3'd5,
      BK_REFRESH = 3'd6
   } bank_st_e;

   typedef enum logic [2:0] {
      OP_NOP, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS, OP_BST
   } op_e;

   typedef enum logic [2:0] {
      ERR_NONE      = 3'd0,
      ERR_NOT_OPEN  = 3'd1,
      ERR_BUSY      = 3'd2,
      ERR_NOT_IDLE  = 3'd3,
      ERR_TRCD      = 3'd4,
      ERR_TRAS      = 3'd5,
      ERR_TRRD      = 3'd6,
      ERR_AP_BURST  = 3'd7
   } err_e;

endpackage

// File: rtl/sdmon_decode.sv
module sdmon_decode
   import sdmon_pkg::*;
(
   input  logic cke_q,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output op_e  op
);
   always_comb begin
      op = OP_NOP;
      if (cke_q && !cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_MRS;
            3'b110:  op = OP_BST;
            default: op = OP_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdmon_bank.sv
module sdmon_bank
   import sdmon_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RP      = 3,
   parameter int T_RC      = 7,
   parameter int BURST_LEN = 4,
   parameter int TW        = 4
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     do_act,
   input  logic     do_rd,
   input  logic     do_wr,
   input  logic     ap,
   input  logic     do_pre,
   input  logic     do_ref,
   input  logic     do_stop,
   output bank_st_e state,
   output logic     ap_q,
   output logic     ras_done
);
   logic [TW-1:0] tmr;
   logic [TW-1:0] ras_cnt;
   logic          dwell;

   assign ras_done = (ras_cnt == '0);
   assign dwell = (state == BK_OPENING) || (state == BK_RD) || (state == BK_WR) ||
                  (state == BK_CLOSING) || (state == BK_REFRESH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_cnt <= '0;
      end else if (do_act) begin
         ras_cnt <= TW'(T_RAS - 1);
      end else if (ras_cnt != '0) begin
         ras_cnt <= ras_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= BK_IDLE;
         tmr   <= '0;
         ap_q  <= 1'b0;
      end else if (do_ref) begin
         state <= BK_REFRESH;
         tmr   <= TW'(T_RC - 1);
      end else if (do_act) begin
         state <= BK_OPENING;
         tmr   <= TW'(T_RCD - 1);
      end else if (do_rd || do_wr) begin
         state <= do_rd ? BK_RD : BK_WR;
         tmr   <= TW'(BURST_LEN - 1);
         ap_q  <= ap;
      end else if (do_pre) begin
         state <= BK_CLOSING;
         tmr   <= TW'(T_RP - 1);
         ap_q  <= 1'b0;
      end else if (do_stop) begin
         state <= BK_OPEN;
         ap_q  <= 1'b0;
      end else if (dwell) begin
         if (tmr == TW'(1)) begin
            case (state)
               BK_OPENING: state <= BK_OPEN;
               BK_RD, BK_WR: begin
                  if (ap_q) begin
                     state <= BK_CLOSING;
                     tmr   <= TW'(T_RP - 1);
                     ap_q  <= 1'b0;
                  end else begin
                     state <= BK_OPEN;
                  end
               end
               default: state <= BK_IDLE;
            endcase
         end else begin
            tmr <= tmr - 1'b1;
         end
      end
   end

   // R5: a row is opened only in a bank that was idle
   a_r5_act_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |-> state == BK_IDLE);
   // R3: column access only reaches a bank that finished opening
   a_r3_access_open: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rd || do_wr) |-> (state == BK_OPEN || state == BK_RD || state == BK_WR));
   // R7: an accepted close never precedes the row-active minimum
   a_r7_close_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
      do_pre |-> ras_done);
   // R3: OPENING is always left towards OPEN
   a_r3_opening_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BK_OPENING && !do_ref && !do_pre) |=> (state == BK_OPENING || state == BK_OPEN));
endmodule

// File: rtl/sdmon_rules.sv
module sdmon_rules
   import sdmon_pkg::*;
#(
   parameter int NB     = 4,
   parameter int BANK_W = 2
)(
   input  op_e               op,
   input  logic [BANK_W-1:0] ba,
   input  logic              a10,
   input  bank_st_e          st [NB],
   input  logic [NB-1:0]     apf,
   input  logic [NB-1:0]     ras_done,
   input  logic              rrd_done,
   output err_e              err,
   output logic [NB-1:0]     act_v,
   output logic [NB-1:0]     rd_v,
   output logic [NB-1:0]     wr_v,
   output logic [NB-1:0]     pre_v,
   output logic [NB-1:0]     stop_v,
   output logic              ref_go,
   output logic              ap_o
);
   logic [NB-1:0] burst_v, open_v, refr_v, busy_v, sel;
   logic          apb_any;
   bank_st_e      tgt;

   for (genvar i = 0; i < NB; i++) begin : g_class
      assign burst_v[i] = (st[i] == BK_RD) || (st[i] == BK_WR);
      assign open_v[i]  = burst_v[i] || (st[i] == BK_OPEN) || (st[i] == BK_OPENING);
      assign refr_v[i]  = (st[i] == BK_REFRESH);
      assign busy_v[i]  = (st[i] != BK_IDLE);
   end

   assign sel     = NB'(1) << ba;
   assign tgt     = st[ba];
   assign apb_any = |(burst_v & apf);

   always_comb begin
      err    = ERR_NONE;
      act_v  = '0;
      rd_v   = '0;
      wr_v   = '0;
      pre_v  = '0;
      stop_v = '0;
      ref_go = 1'b0;
      ap_o   = a10;
      case (op)
         OP_ACT: begin
            if (tgt != BK_IDLE)  err = ERR_BUSY;
            else if (!rrd_done)  err = ERR_TRRD;
            else                 act_v = sel;
         end
         OP_RD, OP_WR: begin
            if (tgt == BK_IDLE || tgt == BK_CLOSING || tgt == BK_REFRESH) err = ERR_NOT_OPEN;
            else if (tgt == BK_OPENING) err = ERR_TRCD;
            else if (apb_any)           err = ERR_AP_BURST;
            else begin
               if (op == OP_RD) rd_v = sel;
               else             wr_v = sel;
               stop_v = burst_v & ~sel;
            end
         end
         OP_PRE: begin
            if (a10) begin
               if (|refr_v)                   err = ERR_BUSY;
               else if (apb_any)              err = ERR_AP_BURST;
               else if (|(open_v & ~ras_done)) err = ERR_TRAS;
               else                           pre_v = open_v;
            end else begin
               if (tgt == BK_REFRESH)                 err = ERR_BUSY;
               else if (|(sel & burst_v & apf))       err = ERR_AP_BURST;
               else if (|(sel & open_v & ~ras_done))  err = ERR_TRAS;
               else                                   pre_v = sel & open_v;
            end
         end
         OP_REF: begin
            if (|busy_v) err = ERR_NOT_IDLE;
            else         ref_go = 1'b1;
         end
         OP_MRS: begin
            if (|busy_v) err = ERR_NOT_IDLE;
         end
         OP_BST: begin
            if (apb_any) err = ERR_AP_BURST;
            else         stop_v = burst_v;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
   import sdmon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RCD     = 3,
   parameter int T_RAS     = 6,
   parameter int T_RP      = 3,
   parameter int T_RRD     = 2,
   parameter int T_RC      = 7,
   parameter int BURST_LEN = 4,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cke,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      ba,
   input  logic                   a10,
   output logic                   err_valid,
   output logic [2:0]             err_code,
   output logic [3*NUM_BANKS-1:0] bank_state
);
   localparam int M1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
   localparam int M2   = (T_RP > T_RC) ? T_RP : T_RC;
   localparam int M3   = (T_RRD > BURST_LEN) ? T_RRD : BURST_LEN;
   localparam int M12  = (M1 > M2) ? M1 : M2;
   localparam int MAXT = (M12 > M3) ? M12 : M3;
   localparam int TW   = $clog2(MAXT + 1);

   if (NUM_BANKS != (1 << BANK_W)) begin : g_chk_nb
      $error("NUM_BANKS must be a power of two");
   end
   if (T_RCD < 2 || T_RP < 2 || T_RC < 2 || BURST_LEN < 2) begin : g_chk_dwell
      $error("dwell timings must be at least 2 clocks");
   end
   if (T_RAS < 1 || T_RRD < 1) begin : g_chk_min
      $error("T_RAS and T_RRD must be at least 1 clock");
   end

   logic              cke_q;
   logic [TW-1:0]     rrd_cnt;
   op_e               op;
   err_e              err, err_q;
   bank_st_e          st [NUM_BANKS];
   logic [NUM_BANKS-1:0] apf, ras_done, act_v, rd_v, wr_v, pre_v, stop_v;
   logic [NUM_BANKS-1:0] burst_obs, refr_obs;
   logic              ref_go, ap_o;

   sdmon_decode u_dec (
      .cke_q (cke_q), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .op (op)
   );

   sdmon_rules #(.NB(NUM_BANKS), .BANK_W(BANK_W)) u_rules (
      .op (op), .ba (ba), .a10 (a10), .st (st), .apf (apf),
      .ras_done (ras_done), .rrd_done (rrd_cnt == '0), .err (err),
      .act_v (act_v), .rd_v (rd_v), .wr_v (wr_v), .pre_v (pre_v),
      .stop_v (stop_v), .ref_go (ref_go), .ap_o (ap_o)
   );

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      sdmon_bank #(
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
         .BURST_LEN(BURST_LEN), .TW(TW)
      ) u_bank (
         .clk (clk), .rst_n (rst_n), .do_act (act_v[i]), .do_rd (rd_v[i]),
         .do_wr (wr_v[i]), .ap (ap_o), .do_pre (pre_v[i]), .do_ref (ref_go),
         .do_stop (stop_v[i]), .state (st[i]), .ap_q (apf[i]),
         .ras_done (ras_done[i])
      );
      assign bank_state[3*i +: 3] = st[i];
      assign burst_obs[i] = (st[i] == BK_RD) || (st[i] == BK_WR);
      assign refr_obs[i]  = (st[i] == BK_REFRESH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q   <= 1'b0;
         rrd_cnt <= '0;
         err_q   <= ERR_NONE;
      end else begin
         cke_q <= cke;
         err_q <= err;
         if (|act_v)              rrd_cnt <= TW'(T_RRD - 1);
         else if (rrd_cnt != '0)  rrd_cnt <= rrd_cnt - 1'b1;
      end
   end

   assign err_valid = (err_q != ERR_NONE);
   assign err_code  = err_q;

   // R9: at most one bank bursts at any time
   a_r9_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(burst_obs) <= 1);
   // R6: refresh holds either no bank or all of them
   a_r6_refresh_all: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(refr_obs) == 0) || ($countones(refr_obs) == NUM_BANKS));
   // R8: an accepted open respects the cross-bank spacing counter
   a_r8_open_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (|act_v) |-> rrd_cnt == '0);
   // R12: a fault pulse lasts one clock unless another fault follows
   a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err == ERR_NONE) |=> !err_valid);
   // R2: nothing is accepted without a qualified command
   a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_q || cs_n) |-> (act_v == '0 && pre_v == '0 && !ref_go && err == ERR_NONE));
endmodule

// File: tb/sdram_bank_monitor_test.sv
module sdram_bank_monitor_test;

   localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                          C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                          C_BST = 3'b110, C_NOP = 3'b111;
   localparam logic [2:0] S_IDLE = 3'd0, S_OPENING = 3'd1, S_OPEN = 3'd2,
                          S_RD = 3'd3, S_WR = 3'd4, S_CLOSING = 3'd5, S_REF = 3'd6;

   logic clk = 1'b0;
   logic rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [1:0]  ba = 2'd0;
   logic        err_valid;
   logic [2:0]  err_code;
   logic [11:0] bank_state;

   always #5 clk = ~clk;

   sdram_bank_monitor uut (
      .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10),
      .err_valid (err_valid), .err_code (err_code), .bank_state (bank_state)
   );

   typedef struct {
      int         stamp;
      bit         is_st;
      int         bank;
      logic [2:0] val;
      bit         errv;
      string      req;
   } item_t;

   item_t q[$];
   item_t keep[$];
   int    edge_no = 0;
   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;

   task automatic push_err(input bit ev, input int ec, input string req);
      item_t it;
      it.stamp = edge_no + 1; it.is_st = 1'b0; it.bank = 0;
      it.val = 3'(ec); it.errv = ev; it.req = req;
      q.push_back(it);
   endtask

   task automatic exp_st(input int b, input logic [2:0] s, input string req);
      item_t it;
      it.stamp = edge_no + 1; it.is_st = 1'b1; it.bank = b;
      it.val = s; it.errv = 1'b0; it.req = req;
      q.push_back(it);
   endtask

   task automatic exp_all(input logic [2:0] s, input string req);
      for (int b = 0; b < 4; b++) exp_st(b, s, req);
   endtask

   task automatic issue(input logic [2:0] pins, input int b, input bit a10v,
                        input bit csn, input bit ev, input int ec, input string req);
      {ras_n, cas_n, we_n} = pins;
      ba = 2'(b); a10 = a10v; cs_n = csn;
      push_err(ev, ec, req);
      @(negedge clk);
      {ras_n, cas_n, we_n} = C_NOP; cs_n = 1'b1; a10 = 1'b0;
   endtask

   task automatic idle(input int k);
      for (int n = 0; n < k; n++) begin
         push_err(1'b0, 0, "R12");
         @(negedge clk);
      end
   endtask

   task automatic check_item(input item_t it);
      logic [3:0] act4, exp4;
      checks++;
      if (it.is_st) begin
         if (bank_state[3*it.bank +: 3] !== it.val) begin
            fails++;
            $display("FAIL %s bank %0d state actual %0d expected %0d", it.req, it.bank,
                     bank_state[3*it.bank +: 3], it.val);
         end
      end else begin
         act4 = {err_valid, err_code};
         exp4 = {it.errv, it.val};
         if (act4 !== exp4) begin
            fails++;
            $display("FAIL %s error actual valid=%0d code=%0d expected valid=%0d code=%0d",
                     it.req, err_valid, err_code, it.errv, it.val);
         end
      end
   endtask

   // monitor: compares due items shortly after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         edge_no++;
         #2;
         keep = {};
         foreach (q[k]) begin
            if (q[k].stamp == edge_no) check_item(q[k]);
            else keep.push_back(q[k]);
         end
         q = keep;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      exp_all(S_IDLE, "R1");
      issue(C_NOP, 0, 0, 1, 0, 0, "R1");
      idle(1);
      // R2: open presented while cke was low one edge earlier is ignored
      cke = 1'b0;
      idle(1);
      cke = 1'b1;
      exp_st(0, S_IDLE, "R2");
      issue(C_ACT, 0, 0, 0, 0, 0, "R2");
      // E0: open bank 0
      exp_st(0, S_OPENING, "R3");
      issue(C_ACT, 0, 0, 0, 0, 0, "R3");
      // E1: open bank 1 too early (R8)
      exp_st(1, S_IDLE, "R12");
      issue(C_ACT, 1, 0, 0, 1, 6, "R8");
      // E2: read bank 0 while opening (R3); bank becomes open at this edge
      exp_st(0, S_OPEN, "R3");
      issue(C_RD, 0, 0, 0, 1, 4, "R3");
      // E3: open bank 1 on time
      exp_st(1, S_OPENING, "R8");
      issue(C_ACT, 1, 0, 0, 0, 0, "R8");
      // E4: open an open bank (R5)
      issue(C_ACT, 0, 0, 0, 1, 2, "R5");
      // E5: close bank 0 one clock early (R7)
      exp_st(0, S_OPEN, "R12");
      issue(C_PRE, 0, 0, 0, 1, 5, "R7");
      // E6: read bank 0
      exp_st(0, S_RD, "R9");
      issue(C_RD, 0, 0, 0, 0, 0, "R9");
      // E7, E8: refresh and mode load with banks open (R6)
      issue(C_REF, 0, 0, 0, 1, 3, "R6");
      exp_st(0, S_RD, "R9");
      issue(C_MRS, 0, 0, 0, 1, 3, "R6");
      // E9: burst ends
      exp_st(0, S_OPEN, "R9");
      idle(1);
      // E10: write bank 1
      exp_st(1, S_WR, "R9");
      issue(C_WR, 1, 0, 0, 0, 0, "R9");
      // E11: read bank 0 ends the write burst on bank 1
      exp_st(0, S_RD, "R9");
      exp_st(1, S_OPEN, "R9");
      issue(C_RD, 0, 0, 0, 0, 0, "R9");
      // E12: burst stop (R11)
      exp_st(0, S_OPEN, "R11");
      issue(C_BST, 0, 0, 0, 0, 0, "R11");
      // E13: read bank 1 with auto-precharge
      exp_st(1, S_RD, "R10");
      issue(C_RD, 1, 1, 0, 0, 0, "R10");
      // E14, E15: interrupting the auto-precharge burst (R10)
      issue(C_WR, 0, 0, 0, 1, 7, "R10");
      exp_st(1, S_RD, "R10");
      issue(C_BST, 0, 0, 0, 1, 7, "R10");
      // E16: last burst clock, bank 1 closing
      exp_st(1, S_CLOSING, "R10");
      idle(1);
      // E17: read a closing bank (R4)
      exp_st(1, S_CLOSING, "R10");
      issue(C_RD, 1, 0, 0, 1, 1, "R4");
      // E18: bank 1 idle
      exp_st(1, S_IDLE, "R10");
      idle(1);
      // E19: read an idle bank (R4)
      issue(C_RD, 2, 0, 0, 1, 1, "R4");
      // E20: close all banks
      exp_st(0, S_CLOSING, "R7");
      exp_st(1, S_IDLE, "R7");
      issue(C_PRE, 0, 1, 0, 0, 0, "R7");
      idle(1);
      exp_st(0, S_IDLE, "R7");
      idle(1);
      // E23: refresh with every bank idle
      exp_all(S_REF, "R6");
      issue(C_REF, 0, 0, 0, 0, 0, "R6");
      // E24, E25: commands during refresh
      issue(C_ACT, 2, 0, 0, 1, 2, "R5");
      issue(C_RD, 3, 0, 0, 1, 1, "R4");
      idle(2);
      exp_all(S_REF, "R6");
      idle(1);
      exp_all(S_IDLE, "R6");
      idle(1);
      // E30: open bank 3, then close early and on time (R7)
      issue(C_ACT, 3, 0, 0, 0, 0, "R3");
      idle(4);
      exp_st(3, S_OPEN, "R12");
      issue(C_PRE, 3, 0, 0, 1, 5, "R7");
      exp_st(3, S_CLOSING, "R7");
      issue(C_PRE, 3, 0, 0, 0, 0, "R7");
      // E37: deselected open is ignored (R2)
      exp_st(0, S_IDLE, "R2");
      issue(C_ACT, 0, 0, 1, 0, 0, "R2");
      exp_st(3, S_IDLE, "R7");
      idle(1);
      // E39: mode load with every bank idle
      exp_all(S_IDLE, "R6");
      issue(C_MRS, 0, 0, 0, 0, 0, "R6");
      idle(3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule